// File: doc/BRIEF.md
# 100BASE-TX Transmit Symbol Encoder

This block turns the nibble stream of a media-independent transmit interface into the three-level line signal of a 100 Mb/s twisted-pair link. The whole block runs on one clock at the serial bit rate. Every fifth cycle it raises a strobe, samples the enable and data nibble, and builds a 5-bit code-group from them. A frame opens with a start-delimiter pair in place of the first preamble byte. Data nibbles pass through a fixed 4-to-5 table. A frame closes with an end-delimiter pair. Between frames the idle code-group is sent without a break, so the far end never loses lock.

Each code-group is shifted out one bit per clock and XORed with a free-running linear feedback key stream. The result is NRZI-coded and then folded into a three-level MLT3 level, which leaves the block as a 2-bit signed value for an external line driver.

Top module: `fx_tx_symbol_enc`

## Requirements
- R1: While `rst_n` is low, `mlt3` is 2'b00 and `nib_take` is 0. Reset is applied at once and released on the second rising clock edge after `rst_n` goes high. The key register restarts at all ones, and the shift register restarts holding the idle code-group.
- R2: `nib_take` is high for exactly one cycle in every five. `tx_en` and `txd` are sampled on the rising edge that ends that cycle. The first such cycle is the fifth cycle after reset release.
- R3: When the encoder is between frames and samples `tx_en` low, it sends the idle code-group 5'b11111.
- R4: When the encoder is between frames and samples `tx_en` high, it sends J = 5'b11000 for that sample and K = 5'b10001 for the next one. The data nibbles of those two samples are not sent.
- R5: Inside a frame, each sample with `tx_en` high sends the nibble through this table (nibble: code-group): 0:11110 1:01001 2:10100 3:10101 4:01010 5:01011 6:01110 7:01111 8:10010 9:10011 A:10110 B:10111 C:11010 D:11011 E:11100 F:11101.
- R6: Inside a frame, the first sample with `tx_en` low sends T = 5'b01101, and the next sample sends R = 5'b00111 whatever `tx_en` and `txd` are. Afterwards the encoder is between frames again.
- R7: The serial bit is XORed with key = s[10]^s[8] of an 11-bit register s. On every clock, s becomes {s[9:0], key}, which is the polynomial x^11 + x^9 + 1.
- R8: A scrambled 1 toggles the NRZI level and a 0 holds it. Each NRZI toggle advances `mlt3` one step around 0, +1, 0, -1, with 0 = 2'b00, +1 = 2'b01 and -1 = 2'b11. `mlt3` never takes the value 2'b10 and never jumps straight between +1 and -1.
- R9: The sample that sends K ignores `tx_en` and `txd`. Even with `tx_en` low it is followed by a data slot, and that slot closes the frame if `tx_en` is still low.
- R10: A code-group sampled on an edge is sent over the next five cycles, bit 0 first. Each bit sets the `mlt3` value seen after the edge that ends its cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock, five times the nibble rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Frame-valid flag from the MAC |
| txd | input | 4 | Transmit data nibble |
| nib_take | output | 1 | High in the cycle whose closing edge samples `tx_en` and `txd` |
| mlt3 | output | 2 | Signed three-level line state |

## Verification
Two things can land in the same sampling edge. A frame can end in the very slot after K, so the closing T follows the delimiter pair with no data between them. A new frame can also be requested during the R slot, so a start arrives while the end delimiter is still going out. The bench provokes the first case by dropping `tx_en` during the K sample. It provokes the second by holding `tx_en` high through the R sample and the sample after it. A behavioural model compares `mlt3` on every clock, so the ignored nibble, the forced R and the J that follows must all show up exactly in the line stream.

// File: rtl/fxtx_pkg.sv
package fxtx_pkg;
  localparam int NIB_W = 4;
  localparam int CG_W  = 5;

  typedef enum logic [1:0] {FR_IDLE, FR_LEAD, FR_DATA, FR_TAIL} fr_state_e;

  localparam logic [CG_W-1:0] CG_IDLE = 5'b11111;
  localparam logic [CG_W-1:0] CG_J    = 5'b11000;
  localparam logic [CG_W-1:0] CG_K    = 5'b10001;
  localparam logic [CG_W-1:0] CG_T    = 5'b01101;
  localparam logic [CG_W-1:0] CG_R    = 5'b00111;

  function automatic logic [CG_W-1:0] map_nibble(input logic [NIB_W-1:0] n);
    logic [CG_W-1:0] c;
    case (n)
      4'h0: c = 5'b11110;
      4'h1: c = 5'b01001;
      4'h2: c = 5'b10100;
      4'h3: c = 5'b10101;
      4'h4: c = 5'b01010;
      4'h5: c = 5'b01011;
      4'h6: c = 5'b01110;
      4'h7: c = 5'b01111;
      4'h8: c = 5'b10010;
      4'h9: c = 5'b10011;
      4'hA: c = 5'b10110;
      4'hB: c = 5'b10111;
      4'hC: c = 5'b11010;
      4'hD: c = 5'b11011;
      4'hE: c = 5'b11100;
      default: c = 5'b11101;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/fxtx_serializer.sv
module fxtx_serializer
  import fxtx_pkg::*;
#(
  parameter int SYM_W = CG_W
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [SYM_W-1:0] cg_i,
  output logic             load_o,
  output logic             bit_o
);
  localparam int CNT_W = $clog2(SYM_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SYM_W - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SYM_W-1:0] sh_q, sh_d;

  always_comb begin
    load_o = (cnt_q == LAST);
    cnt_d  = load_o ? '0 : cnt_q + 1'b1;
    sh_d   = load_o ? cg_i : {1'b1, sh_q[SYM_W-1:1]};
    bit_o  = sh_q[0];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '1;
    end else begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
    end
  end

  p_take_single_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    load_o |=> !load_o);
  p_load_lands_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    load_o |=> (sh_q == $past(cg_i)));
endmodule

// File: rtl/fxtx_framer.sv
module fxtx_framer
  import fxtx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             tx_en_i,
  input  logic [NIB_W-1:0] txd_i,
  output logic [CG_W-1:0]  cg_o
);
  fr_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    cg_o = CG_IDLE;
    case (st_q)
      FR_IDLE: begin
        cg_o = tx_en_i ? CG_J : CG_IDLE;
        st_d = tx_en_i ? FR_LEAD : FR_IDLE;
      end
      FR_LEAD: begin
        cg_o = CG_K;
        st_d = FR_DATA;
      end
      FR_DATA: begin
        cg_o = tx_en_i ? map_nibble(txd_i) : CG_T;
        st_d = tx_en_i ? FR_DATA : FR_TAIL;
      end
      default: begin
        cg_o = CG_R;
        st_d = FR_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) st_q <= FR_IDLE;
    else if (load_i) st_q <= st_d;
  end

  p_frame_close_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (load_i && st_q == FR_DATA && !tx_en_i) |=> (st_q == FR_TAIL));
  p_lead_data_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (load_i && st_q == FR_LEAD) |=> (st_q == FR_DATA));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    !load_i |=> $stable(st_q));
endmodule

// File: rtl/fxtx_scrambler.sv
module fxtx_scrambler #(
  parameter int              W    = 11,
  parameter int              TAP  = 9,
  parameter logic [W-1:0]    SEED = '1
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic bit_i,
  output logic bit_o
);
  logic [W-1:0] s_q, s_d;
  logic         key;

  always_comb begin
    key   = s_q[W-1] ^ s_q[TAP-1];
    bit_o = bit_i ^ key;
    s_d   = {s_q[W-2:0], key};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) s_q <= SEED;
    else         s_q <= s_d;
  end

  p_lfsr_live_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    s_q != '0);
  p_lfsr_shift_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    1'b1 |=> (s_q[W-1:1] == $past(s_q[W-2:0])));
endmodule

// File: rtl/fxtx_mlt3.sv
module fxtx_mlt3 (
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       bit_i,
  output logic [1:0] mlt3_o
);
  logic       nrzi_q, nrzi_d;
  logic       step;
  logic [1:0] ph_q, ph_d;

  always_comb begin
    nrzi_d = nrzi_q ^ bit_i;
    step   = nrzi_d ^ nrzi_q;
    ph_d   = step ? ph_q + 2'd1 : ph_q;
    case (ph_q)
      2'd1:    mlt3_o = 2'b01;
      2'd3:    mlt3_o = 2'b11;
      default: mlt3_o = 2'b00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      nrzi_q <= 1'b0;
      ph_q   <= 2'd0;
    end else begin
      nrzi_q <= nrzi_d;
      ph_q   <= ph_d;
    end
  end

  p_mlt_code_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    mlt3_o != 2'b10);
  p_mlt_hold_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    !bit_i |=> $stable(mlt3_o));
  p_mlt_nojump_pos_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (mlt3_o == 2'b01) |=> (mlt3_o != 2'b11));
  p_mlt_nojump_neg_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (mlt3_o == 2'b11) |=> (mlt3_o != 2'b01));
endmodule

// File: rtl/fx_tx_symbol_enc.sv
module fx_tx_symbol_enc
  import fxtx_pkg::*;
#(
  parameter int                 LFSR_W    = 11,
  parameter int                 LFSR_TAP  = 9,
  parameter logic [LFSR_W-1:0]  LFSR_SEED = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic [NIB_W-1:0] txd,
  output logic             nib_take,
  output logic [1:0]       mlt3
);
  logic [1:0]      rst_sync_q;
  logic            rst_ni;
  logic [CG_W-1:0] cg;
  logic            ser_bit;
  logic            scr_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  fxtx_framer u_framer (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .load_i  (nib_take),
    .tx_en_i (tx_en),
    .txd_i   (txd),
    .cg_o    (cg)
  );

  fxtx_serializer #(.SYM_W(CG_W)) u_ser (
    .clk    (clk),
    .rst_ni (rst_ni),
    .cg_i   (cg),
    .load_o (nib_take),
    .bit_o  (ser_bit)
  );

  fxtx_scrambler #(.W(LFSR_W), .TAP(LFSR_TAP), .SEED(LFSR_SEED)) u_scr (
    .clk    (clk),
    .rst_ni (rst_ni),
    .bit_i  (ser_bit),
    .bit_o  (scr_bit)
  );

  fxtx_mlt3 u_line (
    .clk    (clk),
    .rst_ni (rst_ni),
    .bit_i  (scr_bit),
    .mlt3_o (mlt3)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_ni |-> (mlt3 == 2'b00 && !nib_take));
endmodule

// File: tb/fx_tx_symbol_enc_tb.sv
module fx_tx_symbol_enc_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tx_en;
  logic [3:0] txd;
  logic       nib_take;
  logic [1:0] mlt3;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  fx_tx_symbol_enc u_dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .txd(txd),
    .nib_take(nib_take), .mlt3(mlt3)
  );

  // behavioural reference
  int tbl [16] = '{'h1E, 'h09, 'h14, 'h15, 'h0A, 'h0B, 'h0E, 'h0F,
                   'h12, 'h13, 'h16, 'h17, 'h1A, 'h1B, 'h1C, 'h1D};
  bit q[$];
  int mcnt, lfsr, phase, mst, sync;

  function automatic logic [1:0] lvl(input int p);
    if (p == 1) return 2'b01;
    if (p == 3) return 2'b11;
    return 2'b00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q = {1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
      mcnt = 0; lfsr = 'h7FF; phase = 0; mst = 0; sync = 0;
    end else if (sync < 2) begin
      sync++;
    end else begin
      bit b; int key; int cg;
      b   = q.pop_front();
      key = ((lfsr >> 10) ^ (lfsr >> 8)) & 1;
      lfsr = ((lfsr << 1) | key) & 'h7FF;
      if ((b ^ key[0]) == 1'b1) phase = (phase + 1) % 4;
      if (mcnt == 4) begin
        cg = 'h1F;
        case (mst)
          0: begin cg = tx_en ? 'h18 : 'h1F; mst = tx_en ? 1 : 0; end
          1: begin cg = 'h11; mst = 2; end
          2: begin cg = tx_en ? tbl[txd] : 'h0D; mst = tx_en ? 2 : 3; end
          default: begin cg = 'h07; mst = 0; end
        endcase
        for (int k = 0; k < 5; k++) q.push_back(cg[k]);
      end
      mcnt = (mcnt + 1) % 5;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      checks++;
      if (mlt3 !== 2'b00 || nib_take !== 1'b0) begin
        errors++;
        $display("FAIL R1 reset outputs mlt3=%b nib_take=%b exp mlt3=00 nib_take=0", mlt3, nib_take);
      end
    end else begin
      checks++;
      if (nib_take !== (mcnt == 4)) begin
        errors++;
        $display("FAIL R2 nib_take=%b exp=%b", nib_take, (mcnt == 4));
      end
      checks++;
      if (mlt3 !== lvl(phase)) begin
        errors++;
        $display("FAIL %s (line chain R7 R8 R10) mlt3=%b exp=%b", cur_req, mlt3, lvl(phase));
      end
      checks++;
      if (mlt3 === 2'b10) begin
        errors++;
        $display("FAIL R8 illegal level mlt3=%b exp=not 10", mlt3);
      end
    end
  end

  task automatic slot(input logic en, input logic [3:0] d);
    do @(negedge clk); while (!(sync == 2 && mcnt == 4));
    tx_en = en;
    txd   = d;
    @(posedge clk);
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0; tx_en = 1'b0; txd = 4'h0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tx_en = 1'b0; txd = 4'h0;
    cur_req = "R1";
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    cur_req = "R3";
    repeat (8) slot(1'b0, 4'h0);

    cur_req = "R4";
    slot(1'b1, 4'h5); slot(1'b1, 4'h5);
    cur_req = "R5";
    for (int i = 0; i < 16; i++) slot(1'b1, 4'(i));
    slot(1'b1, 4'hD);
    cur_req = "R6";
    slot(1'b0, 4'h0);
    slot(1'b1, 4'h9);
    cur_req = "R4";
    slot(1'b1, 4'h5);
    cur_req = "R9";
    slot(1'b0, 4'h3);
    cur_req = "R6";
    slot(1'b0, 4'h0); slot(1'b0, 4'h0);
    cur_req = "R3";
    repeat (4) slot(1'b0, 4'h0);

    cur_req = "R5";
    slot(1'b1, 4'h5); slot(1'b1, 4'h5);
    slot(1'b1, 4'hA); slot(1'b1, 4'h3); slot(1'b1, 4'hC);
    cur_req = "R6";
    slot(1'b0, 4'h0);
    slot(1'b1, 4'h7);
    cur_req = "R4";
    slot(1'b1, 4'h5); slot(1'b1, 4'h5);
    slot(1'b1, 4'h8); slot(1'b1, 4'h1);
    slot(1'b0, 4'h0); slot(1'b0, 4'h0);

    cur_req = "R1";
    do_reset();
    cur_req = "R3";
    repeat (6) slot(1'b0, 4'h0);
    cur_req = "R5";
    slot(1'b1, 4'h5); slot(1'b1, 4'h5);
    slot(1'b1, 4'hA); slot(1'b1, 4'h5); slot(1'b1, 4'hF); slot(1'b1, 4'h0);
    cur_req = "R6";
    slot(1'b0, 4'h0); slot(1'b0, 4'h0);
    cur_req = "R7";
    repeat (40) slot(1'b0, 4'h0);
    repeat (3) @(posedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule